// File: doc/BRIEF.md
# Cross-Clock Mailbox Word with Waiting Flag

This block carries a single 36-bit word from port B to port A, bypassing any bulk data path. Port B has its own clock and deposits the word. Port A has a separate, unrelated clock and collects the word. An active-low flag in the port-A clock domain tells port A that a word is waiting. Each port has a direction input and a mailbox-select input, and these two inputs together decide whether a clock edge touches the mailbox.

On the port-B side, a qualifying write edge stores the word and flips a toggle bit. That toggle crosses into the port-A domain through a two-flop synchroniser followed by an edge detector, which produces a one-cycle arrival pulse. A two-state machine in the port-A domain tracks the mailbox:

- MBX_EMPTY: the flag is high.
- MBX_LOADED: the flag is low.

The transitions are named as follows:

- ARRIVE (EMPTY to LOADED): an arrival pulse while empty.
- TAKE (LOADED to EMPTY): a port-A mailbox read with no arrival on the same edge.
- REFILL (LOADED to LOADED): an arrival while a word is already waiting, or an arrival on the same edge as a read.
- Any other edge leaves the state unchanged.

On each arrival, the stored word is copied into a port-A output register. The copy is safe because the storage has stopped changing before the toggle is seen. A port-A output-enable stands in for a tri-state pad and disables the data outputs while port A is in write mode.

Top module: `mbx_b2a`

## Requirements
- R1: While `rst_n` is low, `mbx_wait_n` is 1 and `a_rdata` is 0, and the stored word is cleared to 0.
- R2: A rising `clk_b` edge with `b_dir`=0 (write) and `b_mbx_sel`=1 stores all 36 bits of `b_wdata` as the mailbox word.
- R3: A rising `clk_b` edge with `b_dir`=1 or `b_mbx_sel`=0 leaves the stored word, `a_rdata` and `mbx_wait_n` unchanged.
- R4: After a qualifying port-B write into an empty mailbox, `mbx_wait_n` is still 1 after the second rising `clk_a` edge and is 0 after the third.
- R5: `a_rdata` takes the newly stored word on the same `clk_a` edge on which the arrival reaches the flag logic, and it holds its value on every other edge, including reads.
- R6: A rising `clk_a` edge with `a_dir`=0 (read) and `a_mbx_sel`=1 and no arrival leaves `mbx_wait_n` at 1. This holds both when a word was waiting and when the mailbox was already empty.
- R7: A rising `clk_a` edge with `a_dir`=1 or `a_mbx_sel`=0 and no arrival leaves `mbx_wait_n` unchanged.
- R8: A port-B write while `mbx_wait_n` is 0 keeps the flag at 0, and three `clk_a` edges later `a_rdata` shows the new word.
- R9: When an arrival and a port-A mailbox read fall on the same `clk_a` edge, `mbx_wait_n` is 0 after that edge.
- R10: `a_rdata_oe` is 1 exactly when `a_dir` is 0, independent of the clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| clk_b | input | 1 | Port-B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| b_dir | input | 1 | Port-B direction: 0 write, 1 read |
| b_mbx_sel | input | 1 | Port-B mailbox select |
| b_wdata | input | 36 | Word deposited by port B |
| a_dir | input | 1 | Port-A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port-A mailbox select |
| a_rdata | output | 36 | Mailbox word as seen by port A |
| a_rdata_oe | output | 1 | Drive enable for the port-A data outputs |
| mbx_wait_n | output | 1 | Low while a word is waiting for port A |

## Verification
A synchroniser stage that is lost or doubled moves the fall of `mbx_wait_n` by one `clk_a` edge, so the bench samples on both sides of the third edge after every write. A machine stuck in MBX_LOADED shows up on the very next mailbox read, because the flag then fails to rise. A wrong priority between arrival and read shows up one edge after the coincident event. Corrupt storage or a bad load enable reaches `a_rdata` no later than three `clk_a` edges after the write, and the bench compares every sampled word with the pattern it drove.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int MBX_DATA_W = 36;

    typedef enum logic {
        MBX_EMPTY  = 1'b0,
        MBX_LOADED = 1'b1
    } mbx_state_e;
endpackage

// File: rtl/mbx_wr_side.sv
`timescale 1ns/1ps
module mbx_wr_side #(
    parameter int DATA_W = mbx_pkg::MBX_DATA_W
) (
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              b_dir,
    input  logic              b_mbx_sel,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] store_q,
    output logic              tog_q
);
    logic wr_en;

    assign wr_en = b_mbx_sel & ~b_dir;

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
            tog_q   <= 1'b0;
        end else if (wr_en) begin
            store_q <= b_wdata;
            tog_q   <= ~tog_q;
        end
    end

    assert_capture_R2: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_mbx_sel && !b_dir) |=> (store_q == $past(b_wdata)) && (tog_q != $past(tog_q)));

    assert_no_capture_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_mbx_sel || b_dir) |=> $stable(store_q) && $stable(tog_q));
endmodule

// File: rtl/mbx_toggle_sync.sv
`timescale 1ns/1ps
module mbx_toggle_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic rst_n,
    input  logic tog_in,
    output logic arrive
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          seen_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_a or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tog_in;
                end
            end else begin : g_next
                always_ff @(posedge clk_a or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= sync_q[LAST];
    end

    assign arrive = sync_q[LAST] ^ seen_q;
endmodule

// File: rtl/mbx_rd_side.sv
`timescale 1ns/1ps
module mbx_rd_side #(
    parameter int DATA_W = mbx_pkg::MBX_DATA_W
) (
    input  logic              clk_a,
    input  logic              rst_n,
    input  logic              arrive,
    input  logic              a_dir,
    input  logic              a_mbx_sel,
    input  logic [DATA_W-1:0] store_in,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rdata_oe,
    output logic              mbx_wait_n
);
    import mbx_pkg::*;

    mbx_state_e state_q, state_d;
    logic       take;
    logic [DATA_W-1:0] rdata_q;

    assign take = a_mbx_sel & ~a_dir;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MBX_EMPTY:  if (arrive)     state_d = MBX_LOADED;  // ARRIVE
            MBX_LOADED: if (arrive)     state_d = MBX_LOADED;  // REFILL
                        else if (take)  state_d = MBX_EMPTY;   // TAKE
            default:                    state_d = MBX_EMPTY;
        endcase
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) state_q <= MBX_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (arrive) rdata_q <= store_in;
    end

    always_comb begin
        mbx_wait_n = (state_q == MBX_EMPTY);
        a_rdata    = rdata_q;
        a_rdata_oe = ~a_dir;
    end

    assert_arrive_lowers_flag_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
        arrive |=> !mbx_wait_n);

    assert_take_raises_flag_R6: assert property (@(posedge clk_a) disable iff (!rst_n)
        (take && !arrive) |=> mbx_wait_n);

    assert_idle_holds_flag_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!take && !arrive) |=> $stable(mbx_wait_n));

    assert_rdata_holds_R5: assert property (@(posedge clk_a) disable iff (!rst_n)
        !arrive |=> $stable(a_rdata));
endmodule

// File: rtl/mbx_b2a.sv
`timescale 1ns/1ps
module mbx_b2a #(
    parameter int DATA_W      = mbx_pkg::MBX_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              b_dir,
    input  logic              b_mbx_sel,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              a_dir,
    input  logic              a_mbx_sel,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rdata_oe,
    output logic              mbx_wait_n
);
    logic [DATA_W-1:0] store_q;
    logic              tog_q;
    logic              arrive;

    mbx_wr_side #(.DATA_W(DATA_W)) u_wr (
        .clk_b     (clk_b),
        .rst_n     (rst_n),
        .b_dir     (b_dir),
        .b_mbx_sel (b_mbx_sel),
        .b_wdata   (b_wdata),
        .store_q   (store_q),
        .tog_q     (tog_q)
    );

    mbx_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_a  (clk_a),
        .rst_n  (rst_n),
        .tog_in (tog_q),
        .arrive (arrive)
    );

    mbx_rd_side #(.DATA_W(DATA_W)) u_rd (
        .clk_a      (clk_a),
        .rst_n      (rst_n),
        .arrive     (arrive),
        .a_dir      (a_dir),
        .a_mbx_sel  (a_mbx_sel),
        .store_in   (store_q),
        .a_rdata    (a_rdata),
        .a_rdata_oe (a_rdata_oe),
        .mbx_wait_n (mbx_wait_n)
    );
endmodule

// File: tb/mbx_b2a_bench.sv
`timescale 1ns/1ps
module mbx_b2a_bench;
    logic        clk_a, clk_b, rst_n;
    logic        b_dir, b_mbx_sel, a_dir, a_mbx_sel;
    logic [35:0] b_wdata;
    logic [35:0] a_rdata;
    logic        a_rdata_oe, mbx_wait_n;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;
    logic [35:0] exp_word;

    mbx_b2a u_mbx_b2a (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .b_dir(b_dir), .b_mbx_sel(b_mbx_sel), .b_wdata(b_wdata),
        .a_dir(a_dir), .a_mbx_sel(a_mbx_sel),
        .a_rdata(a_rdata), .a_rdata_oe(a_rdata_oe), .mbx_wait_n(mbx_wait_n)
    );

    // 200 MHz port-A clock: rising edges at 2.5 + 5k ns
    initial begin
        clk_a = 1'b0;
        forever #2.5 clk_a = ~clk_a;
    end

    // port-B clock, period 8 ns, rising edges at 1 + 8k ns (never on a clk_a edge)
    initial begin
        clk_b = 1'b0;
        #1;
        forever begin
            clk_b = 1'b1; #4;
            clk_b = 1'b0; #4;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(input int i);
        return ({4'(i + 1), 32'h0} | (36'h1 << (i * 4))) ^ 36'h0_A5C3_5A3C;
    endfunction

    // one port-B edge with given controls; returns in the time step of that edge
    task automatic b_edge(input logic dir, input logic sel, input logic [35:0] d);
        @(negedge clk_b);
        b_dir = dir; b_mbx_sel = sel; b_wdata = d;
        @(posedge clk_b);
        b_dir <= 1'b1; b_mbx_sel <= 1'b0;
    endtask

    // one port-A edge with given controls; returns 1 ns after that edge
    task automatic a_edge(input logic dir, input logic sel);
        @(negedge clk_a);
        a_dir = dir; a_mbx_sel = sel;
        #0.5;
        chk(a_rdata_oe == !dir, "R10 oe", {35'h0, a_rdata_oe}, {35'h0, !dir});
        @(posedge clk_a);
        a_dir <= 1'b1; a_mbx_sel <= 1'b0;
        #1;
    endtask

    // qualifying write into an empty mailbox, with the arrival timing checked
    task automatic write_fresh(input logic [35:0] d);
        b_edge(1'b0, 1'b1, d);
        repeat (2) @(posedge clk_a);
        #1;
        chk(mbx_wait_n == 1'b1, "R4 early", {35'h0, mbx_wait_n}, 36'h1);
        @(posedge clk_a);
        #1;
        chk(mbx_wait_n == 1'b0, "R4 third edge", {35'h0, mbx_wait_n}, 36'h0);
        chk(a_rdata == d, "R2/R5 word", a_rdata, d);
    endtask

    initial begin
        rst_n = 1'b0;
        b_dir = 1'b1; b_mbx_sel = 1'b0; b_wdata = '0;
        a_dir = 1'b1; a_mbx_sel = 1'b0;
        #13.3;
        chk(mbx_wait_n == 1'b1, "R1 flag", {35'h0, mbx_wait_n}, 36'h1);
        chk(a_rdata == 36'h0, "R1 rdata", a_rdata, 36'h0);
        #10;
        rst_n = 1'b1;
        exp_word = '0;

        // R3: non-qualifying port-B edges, all three other control combinations
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue; // dir=0, sel=1 is the write
            b_edge(1'(c >> 1), 1'(c & 1), 36'hF_0F0F_0F0F);
            repeat (4) @(posedge clk_a);
            #1;
            chk(mbx_wait_n == 1'b1, "R3 flag", {35'h0, mbx_wait_n}, 36'h1);
            chk(a_rdata == exp_word, "R3 word", a_rdata, exp_word);
        end

        // read while empty keeps flag high (R6)
        a_edge(1'b0, 1'b1);
        chk(mbx_wait_n == 1'b1, "R6 empty read", {35'h0, mbx_wait_n}, 36'h1);

        // sweep of data patterns and port-A control combinations
        for (int i = 0; i < 8; i++) begin
            exp_word = pat(i);
            write_fresh(exp_word);
            for (int c = 0; c < 4; c++) begin
                if (c == 1) continue; // dir=0, sel=1 is the read
                a_edge(1'(c >> 1), 1'(c & 1));
                chk(mbx_wait_n == 1'b0, "R7 no take", {35'h0, mbx_wait_n}, 36'h0);
            end
            a_edge(1'b0, 1'b1);
            chk(mbx_wait_n == 1'b1, "R6 take", {35'h0, mbx_wait_n}, 36'h1);
            chk(a_rdata == exp_word, "R5 hold after read", a_rdata, exp_word);
        end

        // R8: overwrite while waiting, boundary words
        write_fresh(36'h0);
        b_edge(1'b0, 1'b1, 36'hF_FFFF_FFFF);
        repeat (2) @(posedge clk_a);
        #1;
        chk(mbx_wait_n == 1'b0, "R8 flag stays low", {35'h0, mbx_wait_n}, 36'h0);
        chk(a_rdata == 36'h0, "R8 old word before arrival", a_rdata, 36'h0);
        @(posedge clk_a);
        #1;
        chk(a_rdata == 36'hF_FFFF_FFFF, "R8 new word", a_rdata, 36'hF_FFFF_FFFF);
        chk(mbx_wait_n == 1'b0, "R8 flag after", {35'h0, mbx_wait_n}, 36'h0);
        a_edge(1'b0, 1'b1);
        chk(mbx_wait_n == 1'b1, "R6 take after R8", {35'h0, mbx_wait_n}, 36'h1);

        // R9: arrival and read on the same clk_a edge
        b_edge(1'b0, 1'b1, 36'h5_1234_5678);
        repeat (2) @(posedge clk_a);
        #1;
        a_dir = 1'b0; a_mbx_sel = 1'b1;
        @(posedge clk_a);
        a_dir <= 1'b1; a_mbx_sel <= 1'b0;
        #1;
        chk(mbx_wait_n == 1'b0, "R9 arrival wins", {35'h0, mbx_wait_n}, 36'h0);
        chk(a_rdata == 36'h5_1234_5678, "R9 word", a_rdata, 36'h5_1234_5678);
        a_edge(1'b0, 1'b1);
        chk(mbx_wait_n == 1'b1, "R6 take after R9", {35'h0, mbx_wait_n}, 36'h1);

        // R10: output enable with clocks irrelevant
        a_dir = 1'b1; #0.3;
        chk(a_rdata_oe == 1'b0, "R10 write mode", {35'h0, a_rdata_oe}, 36'h0);
        a_dir = 1'b0; #0.3;
        chk(a_rdata_oe == 1'b1, "R10 read mode", {35'h0, a_rdata_oe}, 36'h1);
        a_dir = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule